// File: doc/BRIEF.md
# Configurable Expansion-Gate Lattice

This block is a reconfigurable combinational fabric that computes one Boolean function of a small set of primary inputs. It is built from expansion gates stacked in triangular levels. Level n, counted from the top with n = 1, holds 2n-1 gates, so each level below has two more gates than the one above it. Data flows upward to the single top gate, and that gate drives the function output. A row of constant leaf bits sits below the lowest gate level.

Each level takes one control variable, picked from the primary inputs by a per-level index, and every gate on that level shares it. Each gate has two data inputs. Each input chooses one of the three gates directly beneath it and may be complemented. Each gate can act as a Shannon multiplexer, a positive Davio gate or a negative Davio gate, or it can forward its first input.

All selections and leaf values are held in one configuration register. That register is loaded serially through a data/enable pair. After the last bit is in, the output is a purely combinational function of the primary inputs.

Top module: `xlat_fabric`

## Requirements
- R1: While reset is asserted, and after it is released, the configuration register holds all zeros, `cfg_done` is 0 and `fout` is 0 until configuration bits are shifted in.
- R2: On each clock edge with `cfg_en` high, `cfg_din` enters bit 0 of the configuration vector and every existing bit moves one position up. A complete vector is therefore sent most significant bit first. Enabled bits are counted, and idle cycles do not reset the count. `cfg_done` is high for exactly one cycle, in the cycle after the CFG_BITS-th enabled bit. The count then restarts, so a later complete load produces another pulse. With the defaults (3 levels, 4 inputs), CFG_BITS is 85.
- R3: The leaf row has 2*LEVELS+1 positions. Leaf position j is configuration bit j, and position 0 is the leftmost.
- R4: Gate i of a level sits over lower positions i, i+1 and i+2. An input's 2-bit source code selects among them: 0 selects position i, 1 selects position i+1, 2 selects position i+2, and 3 gives constant 0. Both inputs of a gate may name the same source.
- R5: Each input has an invert bit. When the bit is 1, the selected value is complemented, and this includes the constant from source code 3.
- R6: Gate type 00 is Shannon: out = x ? d1 : d0.
- R7: Gate type 01 is positive Davio: out = d0 ^ (x & d1).
- R8: Gate type 10 is negative Davio: out = d0 ^ (~x & d1).
- R9: Gate type 11 passes d0 unchanged.
- R10: Level n's control index occupies XW bits starting at bit LEAF_N + (n-1)*XW, where XW = clog2(NUM_IN). Index k drives the control from `var_in[k]`, and an index of NUM_IN or more gives 0. Gate g, where g = (n-1)^2 + i, occupies 8 bits starting at LEAF_N + LEVELS*XW + 8g. Within those 8 bits, [1:0] is the source of d0, [2] is the invert bit of d0, [4:3] is the source of d1, [5] is the invert bit of d1 and [7:6] is the gate type.
- R11: When `cfg_en` is low, `cfg_din` is ignored and the configuration is held. `fout` then changes only when `var_in` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift-enable for the configuration bit |
| cfg_din | input | 1 | Serial configuration bit |
| var_in | input | NUM_IN | Primary input variables |
| cfg_done | output | 1 | One-cycle pulse after a full vector has been shifted in |
| fout | output | 1 | Function output from the top gate |

## Verification
A wrong leaf bit, source code, invert bit or gate type shows up only at `fout`. It appears as soon as `var_in` takes a value that makes that gate's path observable, and nothing in the block holds it back. Each table configuration is therefore driven with input patterns that sensitise left, centre and right selections, inversions, each gate type and each control index. A miscount in the bit counter shows up at the port as a missing, early or doubled `cfg_done` pulse, and this pulse is checked on every load, including loads with idle gaps and a load that follows a reset in the middle of a vector.

// File: rtl/xlat_fabric.sv
module xlat_fabric #(
  parameter int LEVELS = 3,
  parameter int NUM_IN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_din,
  input  logic [NUM_IN-1:0] var_in,
  output logic              cfg_done,
  output logic              fout
);
  localparam int XW        = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
  localparam int GATES     = LEVELS * LEVELS;
  localparam int LEAF_N    = 2 * LEVELS + 1;
  localparam int NODES     = GATES + LEAF_N;
  localparam int GATE_BASE = LEAF_N + LEVELS * XW;
  localparam int CFG_BITS  = GATE_BASE + 8 * GATES;
  localparam int CW        = $clog2(CFG_BITS + 1);

  logic [CFG_BITS-1:0] cfg;
  logic [CW-1:0]       cnt;
  logic [NODES-1:0]    node;

  function automatic logic pick(input logic [2:0] nb, input logic [1:0] s);
    case (s)
      2'd0:    return nb[0];
      2'd1:    return nb[1];
      2'd2:    return nb[2];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic expand(input logic [1:0] t, input logic x,
                                  input logic d0, input logic d1);
    case (t)
      2'b00:   return x ? d1 : d0;
      2'b01:   return d0 ^ (x & d1);
      2'b10:   return d0 ^ (~x & d1);
      default: return d0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      cnt      <= '0;
      cfg_done <= 1'b0;
    end else begin
      cfg_done <= 1'b0;
      if (cfg_en) begin
        cfg <= {cfg[CFG_BITS-2:0], cfg_din};
        if (cnt == CW'(CFG_BITS - 1)) begin
          cnt      <= '0;
          cfg_done <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign node[GATES +: LEAF_N] = cfg[LEAF_N-1:0];

  for (genvar n = 1; n <= LEVELS; n++) begin : g_lvl
    localparam int CB = LEAF_N + (n - 1) * XW;
    logic [XW-1:0] cidx;
    logic          x;
    assign cidx = cfg[CB +: XW];
    assign x    = (int'(cidx) < NUM_IN) ? var_in[cidx] : 1'b0;

    for (genvar i = 0; i < 2 * n - 1; i++) begin : g_gate
      localparam int G  = (n - 1) * (n - 1) + i;
      localparam int LB = n * n + i;
      localparam int FB = GATE_BASE + 8 * G;
      logic [7:0] c;
      logic [2:0] nb;
      logic       d0, d1;
      assign c  = cfg[FB +: 8];
      assign nb = node[LB +: 3];
      assign d0 = pick(nb, c[1:0]) ^ c[2];
      assign d1 = pick(nb, c[4:3]) ^ c[5];
      assign node[G] = expand(c[7:6], x, d0, d1);
    end
  end

  assign fout = node[0];
endmodule

// File: rtl/xlat_fabric_chk.sv
module xlat_fabric_chk #(
  parameter int NUM_IN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              cfg_done,
  input logic [NUM_IN-1:0] var_in,
  input logic              fout
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else if (cfg_en) seen <= 1'b1;
  end

  p_cleared_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !fout);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> !cfg_done);

  p_done_follows_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> $past(cfg_en));

  p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> ($stable(var_in) -> $stable(fout)));
endmodule

bind xlat_fabric xlat_fabric_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_done(cfg_done),
  .var_in(var_in), .fout(fout)
);

// File: tb/xlat_fabric_bench.sv
module xlat_fabric_bench;
  localparam int NB = 85;
  localparam int NT = 23;
  // entry: {config id, var_in, expected fout}
  localparam logic [7:0] TBL [NT] = '{
    {3'd0, 4'b0000, 1'b0}, {3'd0, 4'b0001, 1'b1}, {3'd0, 4'b0010, 1'b1},
    {3'd0, 4'b0011, 1'b0}, {3'd0, 4'b1101, 1'b1}, {3'd0, 4'b1110, 1'b1},
    {3'd1, 4'b0000, 1'b1}, {3'd1, 4'b0100, 1'b0}, {3'd1, 4'b1000, 1'b0},
    {3'd1, 4'b1100, 1'b0}, {3'd1, 4'b0011, 1'b1},
    {3'd2, 4'b0101, 1'b1}, {3'd2, 4'b0100, 1'b0}, {3'd2, 4'b0001, 1'b0},
    {3'd2, 4'b1111, 1'b1}, {3'd2, 4'b1010, 1'b0},
    {3'd3, 4'b0000, 1'b1}, {3'd3, 4'b1111, 1'b1},
    {3'd4, 4'b0000, 1'b1}, {3'd4, 4'b1010, 1'b1},
    {3'd5, 4'b0110, 1'b0}, {3'd5, 4'b1001, 1'b0},
    {3'd6, 4'b1111, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic cfg_din = 1'b0;
  logic [3:0] var_in = '0;
  logic cfg_done, fout;
  int total = 0;
  int bad = 0;
  bit over = 0;

  logic [1:0] gs0 [9], gs1 [9], gt [9], ctl [3];
  logic       gi0 [9], gi1 [9], lf [7];

  always #2ns clk = ~clk;

  xlat_fabric u_xlat_fabric (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .var_in(var_in), .cfg_done(cfg_done), .fout(fout)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clear_fields();
    for (int g = 0; g < 9; g++) begin
      gs0[g] = 2'd0; gs1[g] = 2'd0; gt[g] = 2'd0; gi0[g] = 1'b0; gi1[g] = 1'b0;
    end
    for (int n = 0; n < 3; n++) ctl[n] = 2'd0;
    for (int j = 0; j < 7; j++) lf[j] = 1'b0;
  endtask

  function automatic logic [NB-1:0] pack();
    logic [NB-1:0] v = '0;
    for (int j = 0; j < 7; j++) v[j] = lf[j];
    for (int n = 0; n < 3; n++) v[7 + 2 * n +: 2] = ctl[n];
    for (int g = 0; g < 9; g++) v[13 + 8 * g +: 8] = {gt[g], gi1[g], gs1[g], gi0[g], gs0[g]};
    return v;
  endfunction

  // lower two levels for configs 0..2: gate1 = x, gate2 = ~x
  task automatic xor_base();
    lf[1] = 1'b1; lf[2] = 1'b1;
    for (int g = 4; g < 9; g++) begin gt[g] = 2'b11; gs0[g] = 2'd0; end
    gs0[1] = 2'd0; gs1[1] = 2'd1;
    gs0[2] = 2'd1; gs1[2] = 2'd2;
  endtask

  task automatic set_cfg(input int id);
    clear_fields();
    case (id)
      0: begin xor_base(); ctl[1] = 2'd1; ctl[0] = 2'd0; gs0[0] = 2'd0; gs1[0] = 2'd1; end
      1: begin xor_base(); ctl[1] = 2'd2; ctl[0] = 2'd3; gt[0] = 2'b01;
               gs0[0] = 2'd0; gi0[0] = 1'b1; gs1[0] = 2'd1; end
      2: begin xor_base(); ctl[1] = 2'd2; gt[0] = 2'b10; gs0[0] = 2'd0; gs1[0] = 2'd0; end
      3: begin gt[0] = 2'b11; gs0[0] = 2'd3; gi0[0] = 1'b1; end
      4: begin lf[3] = 1'b1; gt[0] = 2'b11; gs0[0] = 2'd1;
               gt[2] = 2'b11; gs0[2] = 2'd1; gt[6] = 2'b11; gs0[6] = 2'd1; end
      5: begin for (int j = 1; j < 7; j++) lf[j] = 1'b1;
               gt[0] = 2'b11; gt[1] = 2'b11; gt[4] = 2'b11; end
      default: begin for (int j = 0; j < 7; j++) lf[j] = 1'b1;
               for (int g = 0; g < 9; g++) gt[g] = 2'b11; gs0[0] = 2'd3; end
    endcase
  endtask

  task automatic load(input logic [NB-1:0] v, input bit gaps);
    int early = 0;
    for (int b = NB - 1; b >= 0; b--) begin
      @(negedge clk);
      if (cfg_done) early++;
      cfg_en = 1'b1; cfg_din = v[b];
      if (gaps && (b % 7 == 0) && b != 0) begin
        @(negedge clk);
        if (cfg_done) early++;
        cfg_en = 1'b0; cfg_din = ~cfg_din;
      end
    end
    @(negedge clk);
    cfg_en = 1'b0; cfg_din = 1'b0;
    chk("R2 done pulse after last bit", cfg_done, 1'b1);
    @(negedge clk);
    chk("R2 done lasts one cycle", cfg_done, 1'b0);
    chk("R2 no early done", early != 0, 1'b0);
  endtask

  initial begin
    #(4ns * 200000);
    chk("watchdog expired", 1'b1, 1'b0);
    over = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cur = -1;
    repeat (3) @(negedge clk);
    var_in = 4'b1111;
    #1;
    chk("R1 fout zero in reset", fout, 1'b0);
    chk("R1 done zero in reset", cfg_done, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 fout zero after reset", fout, 1'b0);

    // R3 R4 R5 R6 R7 R8 R9 R10 via table; config 1 loaded with idle gaps (R2)
    for (int k = 0; k < NT; k++) begin
      int id;
      id = int'(TBL[k][7:5]);
      if (id != cur) begin
        set_cfg(id);
        load(pack(), id == 1);
        cur = id;
      end
      @(negedge clk);
      var_in = TBL[k][4:1];
      #1;
      chk($sformatf("R4-table cfg%0d pin=%b (R3/R5/R6/R7/R8/R9/R10)", id, TBL[k][4:1]),
          fout, TBL[k][0]);
    end

    // R11: idle enable ignores serial data
    set_cfg(0);
    load(pack(), 1'b0);
    var_in = 4'b0001;
    begin
      int wrong = 0;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        cfg_din = ~cfg_din;
        #1;
        if (fout !== 1'b1 || cfg_done !== 1'b0) wrong++;
      end
      chk("R11 config held with enable low", wrong != 0, 1'b0);
    end

    // R1 and R2: reset in the middle of a load clears config and count
    for (int b = 0; b < 40; b++) begin
      @(negedge clk); cfg_en = 1'b1; cfg_din = 1'b1;
    end
    @(negedge clk);
    cfg_en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 reset clears function", fout, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    set_cfg(0);
    load(pack(), 1'b0);
    var_in = 4'b0010;
    #1;
    chk("R2 reload after reset", fout, 1'b1);

    if (!over) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule